// File: doc/BRIEF.md
# Step Attenuator Control Register

This block is the control logic that sits in front of a 6-bit RF step attenuator with 0.5 dB resolution, covering 0 dB to 31.5 dB. It takes a mode pin, a serial data pin, a serial shift clock, a latch enable and six parallel data pins. It produces the registered 6-bit attenuation code that drives the switch segments. One code step is 0.5 dB, and code 63 is 31.5 dB.

The block offers three ways to load the code. Serial loading shifts a word in while the latch enable is low and then applies it when the latch enable pulses. Latched parallel loading captures the six pins on a latch enable pulse. Direct parallel loading holds the latch enable high, and the register tracks the pins. All inputs are sampled on the rising edge of the system clock. Edges of the shift clock and of the latch enable are found by comparing each input with its value one clock earlier.

Top module: `dsa_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the attenuation code is 63 (the maximum attenuation) until the first valid load.
- R2: With latch enable low, each rising edge of the shift clock shifts the serial data pin into an 8-bit word. The first bit sent ends up as bit 0, so the word is sent least significant bit first. Only the last eight bits shifted are kept.
- R3: In serial mode (mode pin high), a falling edge of latch enable loads the code from bits 6..1 of the 8-bit word. The word is the attenuation in dB times four: 12.5 dB is sent as 0x32 and gives code 25. The new code is visible one clock after the clock edge that sees latch enable low.
- R4: Bit 0 (the quarter-dB weight) and bit 7 of the serial word have no effect on the loaded code.
- R5: In serial mode, the code does not change while latch enable is high. Rising edges of the shift clock while latch enable is high do not alter the shifted word.
- R6: In parallel mode (mode pin low) with latch enable high, the code follows the parallel pins with one clock of delay (direct parallel).
- R7: In parallel mode with latch enable low, changes on the parallel pins have no effect. A latch enable pulse captures the pins present while it is high (latched parallel).
- R8: Changing the mode pin while latch enable is low does not alter the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset; sets the maximum-attenuation state |
| ser_sel | input | 1 | 1 = serial loading, 0 = parallel loading |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock; rising edges shift |
| latch_en | input | 1 | Latch enable |
| par_data | input | 6 | Parallel attenuation code |
| atten_q | output | 6 | Registered attenuation code (0.5 dB per step) |

## Verification
The serial path is tried with directed words: the 12.5 dB example, all-zeros, all-ones, and words that differ only in bit 0 or bit 7. Random words then show the scaling and the least-significant-first order. Over-long shift sequences tell whether only the last eight bits are kept. Shift clock edges sent while latch enable is high tell ignored edges apart from shifted ones. Parallel stimulus changes the pins with latch enable high and with it low, which separates direct tracking from pulse capture. Mode toggles sent without a load show that only a latch event changes the code.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  localparam int ATT_W_DEF  = 6;
  localparam int SER_W_DEF  = 8;
  localparam int FIELD_LSB  = 1;

  typedef enum logic [1:0] {
    LD_HOLD     = 2'd0,
    LD_SERIAL   = 2'd1,
    LD_PARALLEL = 2'd2
  } load_e;

  // Decide which source, if any, writes the attenuation register this cycle.
  function automatic load_e pick_load(input logic ser_mode,
                                      input logic le_now,
                                      input logic le_fell);
    if (!ser_mode && le_now)
      return LD_PARALLEL;
    if (ser_mode && le_fell)
      return LD_SERIAL;
    return LD_HOLD;
  endfunction

endpackage

// File: rtl/dsa_edge_det.sv
module dsa_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = sig_i & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~sig_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/dsa_shift_reg.sv
module dsa_shift_reg #(
  parameter int SER_W  = 8,
  parameter int ATT_W  = 6,
  parameter int F_LSB  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_i,
  input  logic             le_i,
  output logic [SER_W-1:0] word_o,
  output logic [ATT_W-1:0] field_o
);
  logic [SER_W-1:0] word_q;

  // Right shift: the earliest bit migrates down to bit 0 after SER_W shifts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (shift_en) word_q <= {bit_i, word_q[SER_W-1:1]};
  end

  assign word_o  = word_q;
  assign field_o = word_q[F_LSB +: ATT_W];

  // R5
  le_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_i |=> $stable(word_q));

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> word_q[SER_W-1] == $past(bit_i));
endmodule

// File: rtl/dsa_atten_reg.sv
module dsa_atten_reg
  import dsa_pkg::*;
#(
  parameter int ATT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  load_e            load_i,
  input  logic [ATT_W-1:0] ser_field_i,
  input  logic [ATT_W-1:0] par_i,
  output logic [ATT_W-1:0] atten_o
);
  localparam logic [ATT_W-1:0] MAX_ATT = {ATT_W{1'b1}};

  logic [ATT_W-1:0] atten_q;
  logic             ser_commit;
  logic             par_follow;

  assign ser_commit = (load_i == LD_SERIAL);
  assign par_follow = (load_i == LD_PARALLEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          atten_q <= MAX_ATT;
    else if (ser_commit) atten_q <= ser_field_i;
    else if (par_follow) atten_q <= par_i;
  end

  assign atten_o = atten_q;

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i == LD_HOLD) |=> $stable(atten_q));

  // R3
  ser_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_commit |=> atten_q == $past(ser_field_i));

  // R6
  par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_follow |=> atten_q == $past(par_i));
endmodule

// File: rtl/dsa_ctrl.sv
module dsa_ctrl
  import dsa_pkg::*;
#(
  parameter int ATT_W = dsa_pkg::ATT_W_DEF,
  parameter int SER_W = dsa_pkg::SER_W_DEF,
  parameter int F_LSB = dsa_pkg::FIELD_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_sel,
  input  logic             ser_data,
  input  logic             ser_clk,
  input  logic             latch_en,
  input  logic [ATT_W-1:0] par_data,
  output logic [ATT_W-1:0] atten_q
);
  logic             sclk_rise;
  logic             le_fall;
  logic             shift_en;
  logic [SER_W-1:0] ser_word;
  logic [ATT_W-1:0] ser_field;
  load_e            load_sel;

  dsa_edge_det #(.RISING(1'b1)) u_sclk_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i (ser_clk),
    .edge_o(sclk_rise)
  );

  dsa_edge_det #(.RISING(1'b0)) u_le_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i (latch_en),
    .edge_o(le_fall)
  );

  // Shift edges arriving while the latch is open are discarded.
  assign shift_en = sclk_rise & ~latch_en;

  dsa_shift_reg #(.SER_W(SER_W), .ATT_W(ATT_W), .F_LSB(F_LSB)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .bit_i   (ser_data),
    .le_i    (latch_en),
    .word_o  (ser_word),
    .field_o (ser_field)
  );

  assign load_sel = pick_load(ser_sel, latch_en, le_fall);

  dsa_atten_reg #(.ATT_W(ATT_W)) u_atten (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_sel),
    .ser_field_i(ser_field),
    .par_i      (par_data),
    .atten_o    (atten_q)
  );

  // R5
  ser_le_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel && latch_en) |=> $stable(atten_q));

  // R7
  par_le_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel && !latch_en) |=> $stable(atten_q));

  // R4
  word_edge_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sel == LD_SERIAL) |=> atten_q == $past(ser_word[F_LSB +: ATT_W]));
endmodule

// File: tb/dsa_ctrl_tb.sv
module dsa_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_sel = 1'b1;
  logic       ser_data = 1'b0;
  logic       ser_clk = 1'b0;
  logic       latch_en = 1'b0;
  logic [5:0] par_data = 6'd0;
  logic [5:0] atten_q;

  int total = 0;
  int bad = 0;
  logic [5:0] exp_att;

  always #10 clk = ~clk;

  dsa_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_data(ser_data),
    .ser_clk(ser_clk), .latch_en(latch_en), .par_data(par_data),
    .atten_q(atten_q)
  );

  // Word carries dB*4; a 0.5 dB step is two quarter-dB units; 7-bit range.
  function automatic logic [5:0] code_of_word(input logic [7:0] w);
    int unsigned quarters;
    quarters = w;
    quarters = quarters % 128;
    return 6'(quarters / 2);
  endfunction

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    tick(); ser_data = b; ser_clk = 1'b0;
    tick(); ser_clk = 1'b1;
    tick(); ser_clk = 1'b0;
  endtask

  task automatic shift_word(input logic [7:0] w);
    for (int i = 0; i < 8; i++) shift_bit(w[i]);
  endtask

  task automatic le_pulse();
    tick(); latch_en = 1'b1;
    tick(); latch_en = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] w;
    logic [5:0] p;
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    if (seed_v == 0) seed_v = 1;

    // R1: reset state
    repeat (3) tick();
    chk("R1 in reset", atten_q, 6'd63);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 after reset", atten_q, 6'd63);

    // R3: 12.5 dB example
    ser_sel = 1'b1;
    shift_word(8'h32); le_pulse();
    chk("R3 12.5dB", atten_q, 6'd25);

    // R3 extremes
    shift_word(8'h00); le_pulse();
    chk("R3 zero", atten_q, 6'd0);
    shift_word(8'h7E); le_pulse();
    chk("R3 max", atten_q, 6'd63);

    // R4: bits 0 and 7 ignored
    shift_word(8'hA5); le_pulse();
    chk("R4 bits0/7 set", atten_q, code_of_word(8'hA5));
    shift_word(8'h24); le_pulse();
    chk("R4 bits0/7 clear", atten_q, 6'd18);
    shift_word(8'hFF); le_pulse();
    chk("R4 all ones", atten_q, 6'd63);

    // R2: only last eight bits kept, LSB first
    shift_word(8'hFF); shift_word(8'h14); le_pulse();
    chk("R2 overlong", atten_q, 6'd10);
    shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b1);
    shift_word(8'h02); le_pulse();
    chk("R2 extra leading bits", atten_q, 6'd1);

    // R5: le high freezes code and ignores shift edges
    shift_word(8'h0C);
    tick(); latch_en = 1'b1;
    tick();
    chk("R5 code frozen le high", atten_q, 6'd1);
    shift_bit(1'b1); shift_bit(1'b1);
    chk("R5 code frozen during clocks", atten_q, 6'd1);
    tick(); latch_en = 1'b0;
    tick();
    chk("R5 shift edges ignored", atten_q, 6'd6);

    // R8: mode change alone does nothing
    tick(); par_data = 6'd40; ser_sel = 1'b0;
    repeat (3) tick();
    chk("R8 to parallel", atten_q, 6'd6);
    ser_sel = 1'b1;
    repeat (3) tick();
    chk("R8 back to serial", atten_q, 6'd6);

    // R7: latched parallel
    ser_sel = 1'b0;
    tick(); par_data = 6'd17;
    repeat (2) tick();
    chk("R7 pins ignored le low", atten_q, 6'd6);
    le_pulse();
    chk("R7 pulse capture", atten_q, 6'd17);
    par_data = 6'd50;
    repeat (2) tick();
    chk("R7 held after pulse", atten_q, 6'd17);

    // R6: direct parallel tracking
    tick(); latch_en = 1'b1;
    for (int k = 0; k < 20; k++) begin
      p = 6'($urandom());
      par_data = p;
      tick();
      chk("R6 direct follow", atten_q, p);
    end
    tick(); latch_en = 1'b0;
    tick();

    // Random mix: serial words and latched parallel values
    for (int k = 0; k < 40; k++) begin
      if ($urandom() % 2 == 0) begin
        ser_sel = 1'b1;
        w = 8'($urandom());
        shift_word(w); le_pulse();
        exp_att = code_of_word(w);
        chk("R3 random serial", atten_q, exp_att);
      end else begin
        ser_sel = 1'b0;
        p = 6'($urandom());
        tick(); par_data = p;
        le_pulse();
        exp_att = p;
        par_data = 6'($urandom());
        repeat (2) tick();
        chk("R7 random latched", atten_q, exp_att);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule